// File: doc/BRIEF.md
# Preloadable Down-Counting Wake Timer

This block is a one-shot wake-up timer. At its centre is a 16-bit down counter that advances on a slow timebase. The timebase enters the block as a single-cycle enable pulse, `tick_slow`, in the same clock domain as the register bus. Software arms the timer by writing a start value to the LOAD register. That write is the only start and stop control. A nonzero value starts the countdown. A zero value halts the timer and empties the counter.

When the counter steps from one to zero, it stops there and sets a sticky terminal flag. Software clears the flag by writing one to its bit. The flag reaches the `irq` pin only while the interrupt enable bit is set.

A configuration bit picks the step rate:

- **Fine mode:** the counter steps once per slow tick.
- **Coarse mode:** a prescaler divides the ticks by 4096. With a 32.768 kHz timebase this gives an eighth of a second per step.

Every LOAD write restarts the prescaler, so the first coarse step after a load always comes a full period later.

The register port is a plain one-cycle write strobe with an address. Reads are combinational on the same address lines. There is no back-pressure: every write is taken in the cycle it is presented.

Top module: `wake_countdown_timer`

## Requirements
- R1: After reset, every register reads zero, `irq` is low, and slow ticks do not change the counter.
- R2: A write of a nonzero value to LOAD (address 0) puts that value in COUNT at the next clock edge. This holds even if a tick arrives in the same cycle. LOAD reads back the last value written to it.
- R3: A write of zero to LOAD makes COUNT read zero at the next edge, stops the countdown, and does not set the terminal flag.
- R4: In fine mode (CFG bit 0 clear, CFG at address 1), each `tick_slow` pulse lowers a nonzero COUNT by exactly one. Cycles without a tick leave COUNT unchanged.
- R5: In coarse mode (CFG bit 0 set), COUNT drops by one on every 4096th tick. The prescaler restarts on every LOAD write, so the first step comes on the 4096th tick after that write.
- R6: Once COUNT reaches zero it stays at zero until the next nonzero LOAD write.
- R7: The step that takes COUNT from one to zero sets the terminal flag (STAT bit 0, STAT at address 3). The flag stays set until it is cleared.
- R8: Writing STAT with bit 0 set clears the flag, and writing STAT with bit 0 clear does nothing. When a terminal step and a clearing write fall in the same cycle, the flag ends up set.
- R9: `irq` is high exactly when the terminal flag and the interrupt enable (CFG bit 1) are both set.
- R10: COUNT (address 2) is read-only, so writes to it change nothing. Register bits above the defined fields read zero.
- R11: A write of zero followed by a write of a new value restarts the countdown from the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared bus and counter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_slow | input | 1 | Single-cycle enable marking one slow timebase period |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_addr | input | 2 | Register address for both write and read |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Terminal flag gated by interrupt enable |

## Verification
The bench targets several corner cases, each paired with the failure it would expose:

- **Tick in the same cycle as a LOAD write:** a design that lets the tick win shows one less than the written value.
- **Terminal step together with a flag clear:** a design where the clear wins loses the wake event.
- **Zero write:** a design that treats the resulting zero like a countdown would raise a spurious flag.
- **Prescaler restart on load:** a design that keeps the old prescaler phase across a reload makes the first coarse step too early.
- **Stepping past zero:** a counter that wraps below zero would restart near 65535.
- **Writing the read-only COUNT:** a design that accepts the write would corrupt the count.

// File: rtl/wt_pkg.sv
package wt_pkg;

  typedef enum logic [1:0] {
    REG_LOAD  = 2'd0,
    REG_CFG   = 2'd1,
    REG_COUNT = 2'd2,
    REG_STAT  = 2'd3
  } wt_reg_e;

  localparam int CFG_COARSE_BIT = 0;
  localparam int CFG_IE_BIT     = 1;
  localparam int STAT_TERM_BIT  = 0;

  typedef struct packed {
    logic coarse;
    logic ie;
  } wt_cfg_t;

endpackage

// File: rtl/wt_prescaler.sv
module wt_prescaler #(
  parameter int DIV = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_in,
  input  logic restart,
  input  logic coarse,
  output logic step
);

  generate
    if (DIV < 2) begin : g_bypass
      assign step = tick_in;
    end else begin : g_div
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);

      logic [PW-1:0] phase_q;
      logic          wrap;

      assign wrap = tick_in && (phase_q == LAST);

      always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
          phase_q <= '0;
        end else if (tick_in) begin
          phase_q <= wrap ? '0 : phase_q + PW'(1);
        end
      end

      assign step = coarse ? wrap : tick_in;

      // R5: any LOAD write restarts the division phase
      p_phase_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (phase_q == '0));

      // R5: without a tick the phase holds still
      p_phase_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_in && !restart) |=> $stable(phase_q));
    end
  endgenerate

endmodule

// File: rtl/wt_counter.sv
module wt_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  output logic [W-1:0] count,
  output logic         term
);

  logic [W-1:0] count_q;
  logic         active;

  assign active = (count_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (load) begin
      count_q <= load_val;
    end else if (step && active) begin
      count_q <= count_q - W'(1);
    end
  end

  assign term  = step && !load && (count_q == W'(1));
  assign count = count_q;

  // R2 R3: a load always wins and lands the written value
  p_load_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == $past(load_val)));

  // R4: one step lowers a running count by exactly one
  p_step_by_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && step && count != '0) |=> (count == $past(count) - W'(1)));

  // R4: no step, no load, no change
  p_idle_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(count));

  // R6: zero is sticky until a load
  p_zero_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && count == '0) |=> (count == '0));

endmodule

// File: rtl/wt_regs.sv
module wt_regs
  import wt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_wr,
  input  logic [1:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  input  logic [W-1:0] count,
  input  logic         term,
  output logic [W-1:0] bus_rdata,
  output logic         load,
  output logic [W-1:0] load_val,
  output wt_cfg_t      cfg,
  output logic         flag
);

  wt_reg_e      sel;
  logic [W-1:0] preload_q;
  wt_cfg_t      cfg_q;
  logic         flag_q;
  logic         clr;

  assign sel      = wt_reg_e'(bus_addr);
  assign load     = bus_wr && (sel == REG_LOAD);
  assign load_val = bus_wdata;
  assign clr      = bus_wr && (sel == REG_STAT) && bus_wdata[STAT_TERM_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      preload_q <= '0;
      cfg_q     <= '0;
    end else if (bus_wr) begin
      case (sel)
        REG_LOAD: preload_q <= bus_wdata;
        REG_CFG: begin
          cfg_q.coarse <= bus_wdata[CFG_COARSE_BIT];
          cfg_q.ie     <= bus_wdata[CFG_IE_BIT];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (term) begin
      flag_q <= 1'b1;
    end else if (clr) begin
      flag_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (sel)
      REG_LOAD: bus_rdata = preload_q;
      REG_CFG: begin
        bus_rdata[CFG_COARSE_BIT] = cfg_q.coarse;
        bus_rdata[CFG_IE_BIT]     = cfg_q.ie;
      end
      REG_COUNT: bus_rdata = count;
      REG_STAT:  bus_rdata[STAT_TERM_BIT] = flag_q;
      default:   bus_rdata = '0;
    endcase
  end

  assign cfg  = cfg_q;
  assign flag = flag_q;

  // R7 R8: a terminal step always leaves the flag set, even against a clear
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    term |=> flag);

  // R8: a clearing write without a terminal step drops the flag
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !term) |=> !flag);

  // R7: the flag holds between events
  p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!term && !clr) |=> $stable(flag));

endmodule

// File: rtl/wake_countdown_timer.sv
module wake_countdown_timer
  import wt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int COARSE = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_slow,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             irq
);

  logic             load;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] count;
  logic             term;
  logic             step;
  logic             flag;
  wt_cfg_t          cfg;

  wt_regs #(.W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .count     (count),
    .term      (term),
    .bus_rdata (bus_rdata),
    .load      (load),
    .load_val  (load_val),
    .cfg       (cfg),
    .flag      (flag)
  );

  wt_prescaler #(.DIV(COARSE)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_in (tick_slow),
    .restart (load),
    .coarse  (cfg.coarse),
    .step    (step)
  );

  wt_counter #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .step     (step),
    .count    (count),
    .term     (term)
  );

  assign irq = flag & cfg.ie;

  // R3: a zero load never produces a wake event in the following cycle
  p_zero_load_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val == '0 && !flag) |=> !flag);

endmodule

// File: tb/test_wake_countdown_timer.sv
module test_wake_countdown_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_slow = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wake_countdown_timer i_wake_countdown_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_slow (tick_slow),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  localparam logic [1:0] A_LOAD = 2'd0, A_CFG = 2'd1, A_CNT = 2'd2, A_STAT = 2'd3;

  typedef struct packed {
    logic        wr;
    logic [1:0]  addr;
    logic [15:0] data;
    logic [15:0] nt;
    logic [15:0] cnt;
    logic        flag;
    logic        irq;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VT [NV] = '{
    '{1'b1, 2'd1, 16'h0002, 16'd0, 16'd0, 1'b0, 1'b0}, // ie on, fine
    '{1'b1, 2'd0, 16'd5,    16'd0, 16'd5, 1'b0, 1'b0}, // load 5
    '{1'b0, 2'd0, 16'd0,    16'd3, 16'd2, 1'b0, 1'b0}, // 3 ticks
    '{1'b0, 2'd0, 16'd0,    16'd2, 16'd0, 1'b1, 1'b1}, // reach zero
    '{1'b0, 2'd0, 16'd0,    16'd3, 16'd0, 1'b1, 1'b1}, // sticky zero
    '{1'b1, 2'd3, 16'h0001, 16'd0, 16'd0, 1'b0, 1'b0}, // W1C
    '{1'b1, 2'd0, 16'd3,    16'd1, 16'd2, 1'b0, 1'b0}, // load 3, 1 tick
    '{1'b1, 2'd0, 16'd0,    16'd0, 16'd0, 1'b0, 1'b0}, // zero write
    '{1'b0, 2'd0, 16'd0,    16'd4, 16'd0, 1'b0, 1'b0}, // stopped
    '{1'b1, 2'd1, 16'h0000, 16'd0, 16'd0, 1'b0, 1'b0}, // ie off
    '{1'b1, 2'd0, 16'd1,    16'd1, 16'd0, 1'b1, 1'b0}, // masked wake
    '{1'b1, 2'd1, 16'h0002, 16'd0, 16'd0, 1'b1, 1'b1}, // ie on, irq
    '{1'b1, 2'd3, 16'h0000, 16'd0, 16'd0, 1'b1, 1'b1}, // write 0 no clear
    '{1'b1, 2'd3, 16'h0001, 16'd0, 16'd0, 1'b0, 1'b0}  // clear
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk);
      tick_slow = 1'b1;
      repeat (n) @(negedge clk);
      tick_slow = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk("R1 reset register", v, 16'd0);
    end
    chk("R1 reset irq", {15'd0, irq}, 16'd0);
    ticks(3);
    rd(A_CNT, v);
    chk("R1 stopped after reset", v, 16'd0);

    // vector table: R4 R6 R7 R8 R9 R3
    for (int i = 0; i < NV; i++) begin
      if (VT[i].wr) wr(VT[i].addr, VT[i].data);
      ticks(int'(VT[i].nt));
      @(negedge clk);
      rd(A_CNT, v);
      chk($sformatf("R4 count vector %0d", i), v, VT[i].cnt);
      rd(A_STAT, v);
      chk($sformatf("R7 flag vector %0d", i), v, {15'd0, VT[i].flag});
      chk($sformatf("R9 irq vector %0d", i), {15'd0, irq}, {15'd0, VT[i].irq});
    end

    // R2: tick coincident with load, load wins; readback
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = A_LOAD; bus_wdata = 16'd9; tick_slow = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; tick_slow = 1'b0;
    rd(A_CNT, v);
    chk("R2 load beats tick", v, 16'd9);
    rd(A_LOAD, v);
    chk("R2 load readback", v, 16'd9);

    // R10: COUNT read-only, CFG upper bits read zero
    wr(A_CNT, 16'hFFFF);
    rd(A_CNT, v);
    chk("R10 count read-only", v, 16'd9);
    wr(A_CFG, 16'hFFFE);
    rd(A_CFG, v);
    chk("R10 cfg unused bits zero", v, 16'h0002);

    // R11: restart sequence
    ticks(2);
    rd(A_CNT, v);
    chk("R11 before restart", v, 16'd7);
    wr(A_LOAD, 16'd0);
    rd(A_CNT, v);
    chk("R3 zero write clears", v, 16'd0);
    wr(A_LOAD, 16'd40);
    rd(A_CNT, v);
    chk("R11 new value loaded", v, 16'd40);
    ticks(1);
    rd(A_CNT, v);
    chk("R11 counting from new value", v, 16'd39);

    // R8: set wins against simultaneous clear
    wr(A_LOAD, 16'd1);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = A_STAT; bus_wdata = 16'h0001; tick_slow = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; tick_slow = 1'b0;
    rd(A_STAT, v);
    chk("R8 set wins over clear", v, 16'd1);
    wr(A_STAT, 16'h0001);

    // R5: coarse mode with prescaler restart on load
    wr(A_CFG, 16'h0003);
    wr(A_LOAD, 16'd2);
    ticks(2000);
    wr(A_LOAD, 16'd2);
    ticks(4095);
    rd(A_CNT, v);
    chk("R5 no step before 4096 ticks", v, 16'd2);
    ticks(1);
    rd(A_CNT, v);
    chk("R5 step on 4096th tick", v, 16'd1);
    ticks(4096);
    rd(A_CNT, v);
    chk("R5 second coarse step", v, 16'd0);
    rd(A_STAT, v);
    chk("R7 coarse terminal flag", v, 16'd1);
    chk("R9 coarse irq", {15'd0, irq}, 16'd1);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule